// File: doc/BRIEF.md
# Execution privilege mode controller

This block sits between a small RISC-V style CPU and the memory fabric. It decides whether the CPU runs in firmware, system call or application mode. From reset the CPU runs in firmware mode and fetches from ROM. Once firmware arms the system call path, the first instruction fetch that completes outside ROM drops the CPU into application mode. The hardware makes this change without any register write.

An application gets back into privileged code in one way only. It makes a full-word store to a fixed trigger address. That store raises interrupt line 31. When the CPU then fetches the shared handler entry at 0x0000_0010, the block enters system call mode. A return-from-interrupt pulse clears the source and puts the block back in application mode. The unique device secret remains reachable only while firmware runs from ROM before its first fetch elsewhere. After that it stays hidden until reset, and system call mode does not bring it back.

Every CPU bus request is checked against the current mode. The region is chosen by the top eight address bits. A permitted request is passed to the fabric with `fab_valid`, and the fabric's ready and read data return unchanged. A refused request never reaches the fabric, so the access is invisible. The block itself completes it one cycle later with read data of zero, and any write is dropped. A refused instruction fetch also raises `fetch_fault` in the cycle it completes.

The CPU holds `cpu_valid`, address, strobes and the fetch flag steady until it sees `cpu_ready`. The transfer takes place on the clock edge where both are high, and the request drops or changes after that edge. Address and write data go to the fabric directly from the CPU bus. The block gates only the valid line.

Top module: `priv_mode_ctrl`

## Requirements
- R1: After reset, `mode` is 2'b00 (firmware), `irq_vec` is zero, `secret_en` is 1 and `cpu_ready` is low with no request.
- R2: In firmware or system call mode with `sc_arm` high, a completed fetch whose address top byte is not 8'h00 changes `mode` to 2'b01 (application) on the next cycle. Without `sc_arm` the mode is unchanged, and application mode never returns to firmware mode without reset.
- R3: `secret_en` is 1 only in firmware mode before the first completed fetch outside ROM. Once such a fetch has completed, `secret_en` stays 0 until reset.
- R4: A completed write with `cpu_wstrb` 4'hF to address 32'hE100_0000 sets `irq_vec[31]` from the next cycle. A partial write there does not set it. Bits 30:0 are always zero.
- R5: A completed fetch from 32'h0000_0010 while `irq_vec[31]` is set changes `mode` to 2'b10 (system call). In application mode this fetch is forwarded and is not faulted.
- R6: An `irq_ret` pulse clears `irq_vec[31]`. If the mode was system call, the mode becomes application.
- R7: In application mode a fetch from ROM (top byte 8'h00) other than the handler entry with a pending interrupt is refused. It completes with read data zero, and `fetch_fault` is high in that completion cycle only.
- R8: FW RAM (top byte 8'hD0) and SPI (top byte 8'hCA) accesses are forwarded in firmware and system call modes. In application mode they are invisible.
- R9: The secret region (top byte 8'hC8) is forwarded only while `secret_en` is 1. Otherwise it is invisible.
- R10: Writes to the metadata window are dropped in application mode. The window is top byte 8'hFF with word index `addr[9:2]` from 8'h0C to 8'h27. Reads from the window are forwarded in every mode.
- R11: Writes to ROM are dropped in every mode. ROM reads are forwarded in every mode. Any access to the trigger region (top byte 8'hE1) is completed internally and never forwarded.
- R12: A refused request gets exactly one `cpu_ready` pulse, one cycle after it is presented, with `cpu_rdata` zero. A forwarded request takes `cpu_ready` and `cpu_rdata` from the fabric in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sc_arm | input | 1 | System calls armed by firmware; enables the automatic switch to application mode |
| irq_ret | input | 1 | One-cycle pulse when the CPU returns from interrupt |
| cpu_valid | input | 1 | CPU bus request valid |
| cpu_instr | input | 1 | Request is an instruction fetch |
| cpu_addr | input | 32 | Request byte address |
| cpu_wstrb | input | 4 | Byte write strobes, zero for reads |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_rdata | output | 32 | Read data back to the CPU |
| fab_valid | output | 1 | Request allowed and forwarded to the fabric |
| fab_ready | input | 1 | Fabric completes the forwarded request |
| fab_rdata | input | 32 | Fabric read data |
| mode | output | 2 | Current mode: 00 firmware, 01 application, 10 system call |
| irq_vec | output | 32 | Interrupt request vector, bit 31 for the system call source |
| fetch_fault | output | 1 | Refused instruction fetch completes this cycle |
| secret_en | output | 1 | Enable for the secret store |

## Verification
The assertions assume the CPU holds a request steady until `cpu_ready` and never sends a fetch with write strobes. They also assume `irq_ret` is pulsed only between requests and never in the same cycle as a handler entry fetch. The bench drives each request through one task, which keeps the request up until ready and then drops it for at least one cycle. `irq_ret` and `sc_arm` change only in idle cycles, and fetches always carry zero strobes. The random addresses are drawn from every region, including the exact trigger and handler addresses, so each mode meets every permission case.

// File: rtl/priv_pkg.sv
package priv_pkg;

  typedef enum logic [1:0] {
    MODE_FW  = 2'b00,
    MODE_APP = 2'b01,
    MODE_SYS = 2'b10
  } mode_e;

  typedef enum logic [2:0] {
    RG_ROM,
    RG_FWRAM,
    RG_SPI,
    RG_SECRET,
    RG_TRIG,
    RG_META,
    RG_OTHER
  } region_e;

endpackage

// File: rtl/priv_region_dec.sv
module priv_region_dec
  import priv_pkg::*;
#(
  parameter int          AW           = 32,
  parameter int          PFX_W        = 8,
  parameter logic [7:0]  ROM_PFX      = 8'h00,
  parameter logic [7:0]  FWRAM_PFX    = 8'hD0,
  parameter logic [7:0]  SPI_PFX      = 8'hCA,
  parameter logic [7:0]  SECRET_PFX   = 8'hC8,
  parameter logic [7:0]  TRIG_PFX     = 8'hE1,
  parameter logic [7:0]  CTRL_PFX     = 8'hFF,
  parameter logic [7:0]  META_LO      = 8'h0C,
  parameter logic [7:0]  META_HI      = 8'h27,
  parameter logic [31:0] TRIG_ADDR    = 32'hE100_0000,
  parameter logic [31:0] HANDLER_ADDR = 32'h0000_0010
) (
  input  logic [AW-1:0] addr,
  output region_e       region,
  output logic          trig_hit,
  output logic          handler_hit
);
  localparam int IDX_W = 8;

  logic [PFX_W-1:0] top;
  logic [IDX_W-1:0] widx;

  assign top  = addr[AW-1 -: PFX_W];
  assign widx = addr[IDX_W+1:2];

  always_comb begin
    if (top == ROM_PFX[PFX_W-1:0])              region = RG_ROM;
    else if (top == FWRAM_PFX[PFX_W-1:0])       region = RG_FWRAM;
    else if (top == SPI_PFX[PFX_W-1:0])         region = RG_SPI;
    else if (top == SECRET_PFX[PFX_W-1:0])      region = RG_SECRET;
    else if (top == TRIG_PFX[PFX_W-1:0])        region = RG_TRIG;
    else if (top == CTRL_PFX[PFX_W-1:0] &&
             widx >= META_LO && widx <= META_HI) region = RG_META;
    else                                         region = RG_OTHER;
  end

  assign trig_hit    = (addr == TRIG_ADDR[AW-1:0]);
  assign handler_hit = (addr == HANDLER_ADDR[AW-1:0]);

endmodule

// File: rtl/priv_mode_fsm.sv
module priv_mode_fsm
  import priv_pkg::*;
#(
  parameter int SW     = 4,
  parameter int IRQ_W  = 32,
  parameter int IRQ_SC = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sc_arm,
  input  logic             irq_ret,
  input  logic             xfer,
  input  logic             instr,
  input  logic [SW-1:0]    wstrb,
  input  region_e          region,
  input  logic             trig_hit,
  input  logic             handler_hit,
  output mode_e            mode_q,
  output logic             pend_q,
  output logic             left_rom_q,
  output logic [IRQ_W-1:0] irq_vec
);
  logic  trig_fire, fetch_out, entry;
  mode_e mode_d;

  assign trig_fire = xfer && !instr && (wstrb == {SW{1'b1}}) && trig_hit;
  assign fetch_out = xfer && instr && (region != RG_ROM);
  assign entry     = xfer && instr && handler_hit && pend_q;

  always_comb begin
    mode_d = mode_q;
    if (irq_ret && mode_q == MODE_SYS)                     mode_d = MODE_APP;
    else if (entry)                                        mode_d = MODE_SYS;
    else if (fetch_out && sc_arm && mode_q != MODE_APP)    mode_d = MODE_APP;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q     <= MODE_FW;
      pend_q     <= 1'b0;
      left_rom_q <= 1'b0;
    end else begin
      mode_q     <= mode_d;
      left_rom_q <= left_rom_q | fetch_out;
      if (trig_fire)    pend_q <= 1'b1;
      else if (irq_ret) pend_q <= 1'b0;
    end
  end

  always_comb begin
    irq_vec         = '0;
    irq_vec[IRQ_SC] = pend_q;
  end

  // R2
  app_no_fw_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_APP) |=> (mode_q != MODE_FW));

  // R5
  sys_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_q == MODE_SYS) |-> $past(xfer && instr && handler_hit));

  // R6
  sys_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_SYS && irq_ret && !xfer) |=> (mode_q == MODE_APP && !pend_q));

  // R4
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(xfer && trig_hit && wstrb == {SW{1'b1}}));

endmodule

// File: rtl/priv_access_gate.sv
module priv_access_gate
  import priv_pkg::*;
#(
  parameter int DW = 32,
  parameter int SW = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_valid,
  input  logic          instr,
  input  logic [SW-1:0] wstrb,
  input  region_e       region,
  input  logic          handler_hit,
  input  mode_e         mode_q,
  input  logic          pend_q,
  input  logic          left_rom_q,
  input  logic          fab_ready,
  input  logic [DW-1:0] fab_rdata,
  output logic          fab_valid,
  output logic          cpu_ready,
  output logic [DW-1:0] cpu_rdata,
  output logic          fetch_fault
);
  logic allow, is_write, priv, blk_req, ack_q, fault_q;

  assign is_write = (wstrb != '0);
  assign priv     = (mode_q != MODE_APP);

  always_comb begin
    unique case (region)
      RG_ROM:    allow = instr ? (priv || (handler_hit && pend_q)) : !is_write;
      RG_FWRAM,
      RG_SPI:    allow = priv;
      RG_SECRET: allow = (mode_q == MODE_FW) && !left_rom_q;
      RG_TRIG:   allow = 1'b0;
      RG_META:   allow = instr || !is_write || priv;
      default:   allow = 1'b1;
    endcase
  end

  assign fab_valid = cpu_valid && allow;
  assign blk_req   = cpu_valid && !allow;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_q   <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      ack_q   <= blk_req && !ack_q;
      fault_q <= blk_req && instr && !ack_q;
    end
  end

  assign cpu_ready   = cpu_valid && (allow ? fab_ready : ack_q);
  assign cpu_rdata   = fab_valid ? fab_rdata : '0;
  assign fetch_fault = fault_q;

  // R7
  fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_fault |-> (cpu_ready && cpu_rdata == '0));

  // R12
  ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && !fab_valid && cpu_ready) |=> !ack_q);

endmodule

// File: rtl/priv_mode_ctrl.sv
module priv_mode_ctrl
  import priv_pkg::*;
#(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int IRQ_W  = 32,
  parameter int IRQ_SC = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sc_arm,
  input  logic             irq_ret,
  input  logic             cpu_valid,
  input  logic             cpu_instr,
  input  logic [AW-1:0]    cpu_addr,
  input  logic [DW/8-1:0]  cpu_wstrb,
  output logic             cpu_ready,
  output logic [DW-1:0]    cpu_rdata,
  output logic             fab_valid,
  input  logic             fab_ready,
  input  logic [DW-1:0]    fab_rdata,
  output logic [1:0]       mode,
  output logic [IRQ_W-1:0] irq_vec,
  output logic             fetch_fault,
  output logic             secret_en
);
  localparam int SW = DW / 8;

  region_e region;
  logic    trig_hit, handler_hit, pend_q, left_rom_q, xfer;
  mode_e   mode_q;

  assign xfer = cpu_valid && cpu_ready;

  priv_region_dec #(.AW(AW)) u_dec (
    .addr        (cpu_addr),
    .region      (region),
    .trig_hit    (trig_hit),
    .handler_hit (handler_hit)
  );

  priv_mode_fsm #(.SW(SW), .IRQ_W(IRQ_W), .IRQ_SC(IRQ_SC)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .sc_arm      (sc_arm),
    .irq_ret     (irq_ret),
    .xfer        (xfer),
    .instr       (cpu_instr),
    .wstrb       (cpu_wstrb),
    .region      (region),
    .trig_hit    (trig_hit),
    .handler_hit (handler_hit),
    .mode_q      (mode_q),
    .pend_q      (pend_q),
    .left_rom_q  (left_rom_q),
    .irq_vec     (irq_vec)
  );

  priv_access_gate #(.DW(DW), .SW(SW)) u_gate (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_valid   (cpu_valid),
    .instr       (cpu_instr),
    .wstrb       (cpu_wstrb),
    .region      (region),
    .handler_hit (handler_hit),
    .mode_q      (mode_q),
    .pend_q      (pend_q),
    .left_rom_q  (left_rom_q),
    .fab_ready   (fab_ready),
    .fab_rdata   (fab_rdata),
    .fab_valid   (fab_valid),
    .cpu_ready   (cpu_ready),
    .cpu_rdata   (cpu_rdata),
    .fetch_fault (fetch_fault)
  );

  assign mode      = mode_q;
  assign secret_en = (mode_q == MODE_FW) && !left_rom_q;

  // R8
  app_fwram_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && cpu_valid && cpu_addr[AW-1 -: 8] == 8'hD0) |-> !fab_valid);

  // R3
  secret_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && cpu_instr && cpu_addr[AW-1 -: 8] != 8'h00) |=> !secret_en);

endmodule

// File: tb/priv_mode_ctrl_tb.sv
module priv_mode_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sc_arm = 1'b0;
  logic        irq_ret = 1'b0;
  logic        cpu_valid = 1'b0;
  logic        cpu_instr = 1'b0;
  logic [31:0] cpu_addr = '0;
  logic [3:0]  cpu_wstrb = '0;
  logic        cpu_ready, fab_valid, fab_ready, fetch_fault, secret_en;
  logic [31:0] cpu_rdata, fab_rdata, irq_vec;
  logic [1:0]  mode;

  int checks = 0;
  int fails  = 0;

  logic [1:0] e_mode;
  logic       e_pend, e_left;

  always #4 clk = ~clk;

  assign fab_ready = fab_valid;
  assign fab_rdata = {cpu_addr[15:0], 16'hBEEF};

  priv_mode_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .sc_arm(sc_arm), .irq_ret(irq_ret),
    .cpu_valid(cpu_valid), .cpu_instr(cpu_instr), .cpu_addr(cpu_addr),
    .cpu_wstrb(cpu_wstrb), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .fab_valid(fab_valid), .fab_ready(fab_ready), .fab_rdata(fab_rdata),
    .mode(mode), .irq_vec(irq_vec), .fetch_fault(fetch_fault),
    .secret_en(secret_en)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit exp_allow(input logic [31:0] a, input logic [3:0] ws,
                                   input logic ins);
    logic [7:0] t;
    bit priv, wr, meta;
    t    = a[31:24];
    priv = (e_mode != 2'b01);
    wr   = (ws != 4'h0);
    meta = (t == 8'hFF) && (a[9:2] >= 8'h0C) && (a[9:2] <= 8'h27);
    if (t == 8'h00)                   return ins ? (priv || (a == 32'h10 && e_pend)) : !wr;
    if (t == 8'hD0 || t == 8'hCA)     return priv;
    if (t == 8'hC8)                   return (e_mode == 2'b00) && !e_left;
    if (t == 8'hE1)                   return 1'b0;
    if (meta)                         return ins || !wr || priv;
    return 1'b1;
  endfunction

  task automatic model_xfer(input logic [31:0] a, input logic [3:0] ws, input logic ins);
    bit rom;
    rom = (a[31:24] == 8'h00);
    if (ins && a == 32'h10 && e_pend)                     e_mode = 2'b10;
    else if (ins && !rom && sc_arm && e_mode != 2'b01)    e_mode = 2'b01;
    if (ins && !rom) e_left = 1'b1;
    if (!ins && ws == 4'hF && a == 32'hE100_0000) e_pend = 1'b1;
  endtask

  task automatic check_state(input string req);
    chk(mode == e_mode, {req, " mode"}, {30'd0, mode}, {30'd0, e_mode});
    chk(irq_vec == {e_pend, 31'd0}, {req, " irq_vec"}, irq_vec, {e_pend, 31'd0});
    chk(secret_en == (e_mode == 2'b00 && !e_left), {req, " secret_en"},
        {31'd0, secret_en}, {31'd0, (e_mode == 2'b00 && !e_left)});
  endtask

  task automatic access(input logic [31:0] a, input logic [3:0] ws,
                        input logic ins, input string req);
    bit efwd;
    int waitc;
    logic fv, flt;
    logic [31:0] rd, erd;
    efwd = exp_allow(a, ws, ins);
    erd  = efwd ? {a[15:0], 16'hBEEF} : 32'h0;
    @(negedge clk);
    cpu_valid = 1'b1; cpu_addr = a; cpu_wstrb = ws; cpu_instr = ins;
    #1;
    fv = fab_valid;
    waitc = 0;
    while (!cpu_ready && waitc < 4) begin
      @(negedge clk); #1; waitc++;
    end
    rd  = cpu_rdata;
    flt = fetch_fault;
    chk(fv == efwd, {req, " forward"}, {31'd0, fv}, {31'd0, efwd});
    chk(rd == erd, {req, " rdata R12"}, rd, erd);
    chk(flt == (ins && !efwd), {req, " fetch_fault R7"}, {31'd0, flt}, {31'd0, ins && !efwd});
    chk(waitc == (efwd ? 0 : 1), {req, " ready timing R12"}, waitc, efwd ? 0 : 1);
    @(negedge clk);
    cpu_valid = 1'b0; cpu_instr = 1'b0; cpu_wstrb = '0;
    model_xfer(a, ws, ins);
    #1;
    chk(fetch_fault == 1'b0, {req, " fault one cycle R7"}, {31'd0, fetch_fault}, 32'd0);
    check_state(req);
  endtask

  task automatic pulse_ret(input string req);
    @(negedge clk); irq_ret = 1'b1;
    @(negedge clk); irq_ret = 1'b0;
    if (e_mode == 2'b10) e_mode = 2'b01;
    e_pend = 1'b0;
    #1;
    check_state(req);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; sc_arm = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    e_mode = 2'b00; e_pend = 1'b0; e_left = 1'b0;
    #1;
  endtask

  function automatic logic [31:0] rand_addr();
    logic [31:0] r;
    r = $urandom;
    case ($urandom % 10)
      0: return {8'h00, 12'h0, r[11:2], 2'b00};
      1: return 32'h0000_0010;
      2: return {8'hD0, 12'h0, r[11:2], 2'b00};
      3: return {8'hCA, 16'h0, r[7:2], 2'b00};
      4: return {8'hC8, 19'h0, r[4:2], 2'b00};
      5: return 32'hE100_0000;
      6: return {8'hFF, 14'h0, r[7:0], 2'b00};
      7: return {8'h40, 8'h0, r[15:2], 2'b00};
      8: return {8'hE1, 16'h0, r[7:2], 2'b00};
      default: return {8'hC3, 16'h0, r[7:2], 2'b00};
    endcase
  endfunction

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250226));
    do_reset();
    // R1 reset state
    check_state("R1");
    chk(cpu_ready == 1'b0, "R1 ready idle", {31'd0, cpu_ready}, 32'd0);

    access(32'hC800_0004, 4'h0, 1'b0, "R9 secret read fw");
    access(32'h0000_0100, 4'hF, 1'b0, "R11 rom write dropped");
    access(32'h0000_0200, 4'h0, 1'b1, "R2 rom fetch fw");
    access(32'hD000_0010, 4'hF, 1'b0, "R8 fwram write fw");
    access(32'hE100_0000, 4'h3, 1'b0, "R4 partial trigger");
    access(32'h4000_0000, 4'h0, 1'b1, "R2 unarmed fetch stays fw");
    access(32'hC800_0000, 4'h0, 1'b0, "R9 secret hidden after leave R3");
    @(negedge clk); sc_arm = 1'b1;
    access(32'h4000_0004, 4'h0, 1'b1, "R2 armed fetch to app");
    access(32'hD000_0000, 4'h0, 1'b0, "R8 fwram read app");
    access(32'hCA00_0008, 4'hF, 1'b0, "R8 spi write app");
    access(32'hFF00_0030, 4'hF, 1'b0, "R10 meta write app");
    access(32'hFF00_0034, 4'h0, 1'b0, "R10 meta read app");
    access(32'hFF00_00A0, 4'hF, 1'b0, "R10 outside window");
    access(32'h0000_0100, 4'h0, 1'b1, "R7 rom fetch app");
    access(32'h0000_0100, 4'h0, 1'b0, "R11 rom read app");
    access(32'h0000_0010, 4'h0, 1'b1, "R7 handler without pending");
    access(32'hE100_0000, 4'hF, 1'b0, "R4 trigger");
    access(32'h0000_0010, 4'h0, 1'b1, "R5 handler entry");
    access(32'hD000_0040, 4'h0, 1'b0, "R8 fwram read sys");
    access(32'hC800_0000, 4'h0, 1'b0, "R9 secret in sys");
    access(32'h0000_0044, 4'h0, 1'b1, "R5 rom fetch sys");
    pulse_ret("R6 return");

    do_reset();
    check_state("R1 second reset");
    for (int i = 0; i < 600; i++) begin
      logic [31:0] a;
      logic ins;
      logic [3:0] ws;
      int r;
      r = $urandom % 16;
      if (r == 0 && e_mode == 2'b10) pulse_ret("R6 random return");
      else if (r == 1) begin @(negedge clk); sc_arm = ~sc_arm; end
      else begin
        a   = rand_addr();
        ins = ($urandom % 3) == 0;
        case ($urandom % 3)
          0: ws = 4'h0;
          1: ws = 4'hF;
          default: ws = 4'h3;
        endcase
        if (ins) ws = 4'h0;
        access(a, ws, ins, "R8 R9 R10 R11 random");
      end
      if (i == 300) do_reset();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule